// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a single-port synchronous static RAM of 32-bit words with an internal burst address generator. Address, write data and every control except output enable are sampled on the rising clock edge. An access starts either when the address strobe loads a new base address or when the advance input steps the internal 2-bit burst counter. The counter supplies the two low address bits, so a burst reaches up to four words before it wraps. A mode input selects how the low bits are formed: linear, where they are the start bits plus the count modulo 4, or interleaved, where they are the start bits XOR the count.

Writes are self-timed. The operation is captured at one edge and committed to the array at the next edge, with no further strobes. A global write enable writes the whole word. A byte-write enable, qualified by four lane strobes, writes only the selected 8-bit lanes. Reads pass through an output data register. Output enable and sleep gate the visible data without a clock. A high-impedance bus is modelled as a cleared valid flag with the data forced to zero.

The depth is `2**ADDR_W` words. The full-size instance sets `ADDR_W` to 15, giving 32768 words. The default of 11 keeps the elaborated array small.

Top module: `sbsram_top`

## Requirements
- R1: The storage holds `2**ADDR_W` words of 32 bits, and a word written at an address is returned unchanged by a later read of that address.
- R2: A read captured at rising edge N shows its word on `rdata`, with `rdata_valid` high, from just after edge N+1 until edge N+2.
- R3: A cycle with `addr_load` high accesses exactly `addr`, makes `addr` the burst base and resets the burst counter to 0.
- R4: With `burst_mode` = 0 (linear), a cycle with `burst_adv` high and `addr_load` low increments the counter. It accesses the base with low two bits equal to (base low bits + counter) mod 4.
- R5: With `burst_mode` = 1 (interleaved), an advance cycle accesses the base with low two bits equal to (base low bits XOR counter).
- R6: The counter is two bits wide, so the advance after the fourth word of a burst returns to the starting word.
- R7: When `wr_all` is high, the access writes all four lanes, whatever the value of `byte_sel`.
- R8: When `wr_all` is low and `wr_byte_en` is high, only the lanes with `byte_sel[i]` = 1 are written (lane i is bits 8i+7..8i). When both enables are low, `byte_sel` is ignored and the access is a read.
- R9: While `out_en` is low, `rdata_valid` is 0 and `rdata` is 0 within the same cycle. Raising `out_en` again restores the registered word without a clock edge.
- R10: While `sleep` is high, captured cycles are ignored: there are no writes, and the base and counter are unchanged. In the same period `rdata_valid` is 0 and memory contents are kept. Operation resumes at the first edge with `sleep` low.
- R11: Synchronous reset clears the output register, the valid flag, the base and the counter, so `rdata_valid` and `rdata` read 0 after a reset edge.
- R12: A cycle with neither `addr_load` nor `burst_adv` high performs no access, and `rdata_valid` is 0 after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Low-power hold: ignores cycles and disables outputs |
| addr_load | input | 1 | Address strobe: load new base and access it |
| burst_adv | input | 1 | Advance the burst counter and access the next word |
| burst_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| wr_all | input | 1 | Global write of all four lanes |
| wr_byte_en | input | 1 | Enables lane writes selected by byte_sel |
| byte_sel | input | 4 | Per-lane write strobes |
| wdata | input | 32 | Write data |
| out_en | input | 1 | Asynchronous output enable |
| rdata | output | 32 | Registered read data, zero when not valid |
| rdata_valid | output | 1 | Read data driven (low models high impedance) |

## Verification
A wrong burst counter or base register does not show at once. It shows one edge later, as the wrong word on `rdata` for an advance read. For this reason the table walks full four-word bursts in both orders, from non-zero start offsets, and through the wrap. A bad lane mask or a write that leaks while asleep stays hidden in the array until that address is read back. Each such write is therefore followed within a few cycles by a read of the same or a neighbouring word. A wrong output gate shows within the same cycle, so it is probed a nanosecond after toggling `out_en`.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = 4;
    localparam int LANE_W  = DATA_W / LANES;
    localparam int BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [LANES-1:0]  lane_we;
        logic [DATA_W-1:0] wdata;
    } mem_op_t;

    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input burst_order_e       order
    );
        if (order == ORD_INTERLEAVE)
            return start ^ step;
        else
            return start + step;
    endfunction

endpackage

// File: rtl/sbsram_burst_gen.sv
module sbsram_burst_gen
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              addr_load,
    input  logic              burst_adv,
    input  logic              burst_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt   = cnt_q + 1'b1;
        acc_valid = !sleep && (addr_load || burst_adv);
        if (addr_load)
            acc_addr = addr_in;
        else
            acc_addr = {base_q[ADDR_W-1:BURST_W],
                        burst_low(base_q[BURST_W-1:0], cnt_nxt,
                                  burst_order_e'(burst_mode))};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!sleep) begin
            if (addr_load) begin
                base_q <= addr_in;
                cnt_q  <= '0;
            end else if (burst_adv) begin
                cnt_q  <= cnt_nxt;
            end
        end
    end

    // R3: a load restarts the burst at count zero
    p_load_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (!sleep && addr_load) |=> (cnt_q == '0));

    // R6: an advance steps the 2-bit count with wrap
    p_adv_wraps_r6: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !addr_load && burst_adv) |=>
        (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));

    // R10: burst state frozen while asleep
    p_sleep_holds_r10: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(cnt_q) && $stable(base_q)));

endmodule

// File: rtl/sbsram_lane_ctrl.sv
module sbsram_lane_ctrl
    import sbsram_pkg::*;
(
    input  logic             wr_all,
    input  logic             wr_byte_en,
    input  logic [LANES-1:0] byte_sel,
    output logic             is_write,
    output logic [LANES-1:0] lane_we
);

    assign is_write = wr_all | wr_byte_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = wr_all | (wr_byte_en & byte_sel[g]);
    end

endmodule

// File: rtl/sbsram_store.sv
module sbsram_store
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_write,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (op_valid && op_write) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_we[l])
                    mem[op_addr][l*LANE_W +: LANE_W] <= op_wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= op_valid && !op_write;
            if (op_valid && !op_write)
                rd_data <= mem[op_addr];
        end
    end

    // R12: output register only changes for a read operation
    p_hold_without_read_r12: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && !op_write) |=> $stable(rd_data));

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              addr_load,
    input  logic              burst_adv,
    input  logic              burst_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_all,
    input  logic              wr_byte_en,
    input  logic [3:0]        byte_sel,
    input  logic [31:0]       wdata,
    input  logic              out_en,
    output logic [31:0]       rdata,
    output logic              rdata_valid
);

    logic              acc_valid;
    logic [ADDR_W-1:0] acc_addr;
    logic              is_write;
    logic [LANES-1:0]  lane_we;
    mem_op_t           op_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    sbsram_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .sleep     (sleep),
        .addr_load (addr_load),
        .burst_adv (burst_adv),
        .burst_mode(burst_mode),
        .addr_in   (addr),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr)
    );

    sbsram_lane_ctrl u_lanes (
        .wr_all    (wr_all),
        .wr_byte_en(wr_byte_en),
        .byte_sel  (byte_sel),
        .is_write  (is_write),
        .lane_we   (lane_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= '0;
            op_addr_q <= '0;
        end else begin
            op_q.valid   <= acc_valid;
            op_q.write   <= is_write;
            op_q.lane_we <= lane_we;
            op_q.wdata   <= wdata;
            op_addr_q    <= acc_addr;
        end
    end

    sbsram_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .op_valid(op_q.valid),
        .op_write(op_q.write),
        .lane_we (op_q.lane_we),
        .op_addr (op_addr_q),
        .op_wdata(op_q.wdata),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    always_comb begin
        rdata_valid = rd_valid && out_en && !sleep;
        rdata       = rdata_valid ? rd_data : '0;
    end

    // R2: visible data traces back to a read accepted two edges earlier
    p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(acc_valid && !is_write, 2));

    // R10: a sleeping cycle launches no operation
    p_sleep_no_op_r10: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !op_q.valid);

endmodule

// File: tb/sbsram_top_test.sv
module sbsram_top_test;

    logic        clk = 1'b0;
    logic        rst, sleep, addr_load, burst_adv, burst_mode;
    logic [10:0] addr;
    logic        wr_all, wr_byte_en;
    logic [3:0]  byte_sel;
    logic [31:0] wdata;
    logic        out_en;
    logic [31:0] rdata;
    logic        rdata_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    sbsram_top #(.ADDR_W(11)) uut (
        .clk(clk), .rst(rst), .sleep(sleep), .addr_load(addr_load),
        .burst_adv(burst_adv), .burst_mode(burst_mode), .addr(addr),
        .wr_all(wr_all), .wr_byte_en(wr_byte_en), .byte_sel(byte_sel),
        .wdata(wdata), .out_en(out_en), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    typedef struct packed {
        logic        ld;
        logic        adv;
        logic        wa;
        logic        wbe;
        logic [3:0]  bs;
        logic        md;
        logic [10:0] ad;
        logic [31:0] wd;
        logic        ev;
        logic [31:0] ed;
        logic [3:0]  rq;
    } vec_t;

    // Expected result in row i is the outcome of row i-1's access.
    localparam vec_t VECS [23] = '{
        '{1'b1,1'b0,1'b1,1'b0,4'h0,1'b0,11'h010,32'h100000A0,1'b0,32'h0,4'd3},  // R3 write 010
        '{1'b0,1'b1,1'b1,1'b0,4'h0,1'b0,11'h000,32'h200000A1,1'b0,32'h0,4'd4},  // R4 write 011
        '{1'b0,1'b1,1'b1,1'b0,4'h0,1'b0,11'h000,32'h300000A2,1'b0,32'h0,4'd4},  // R4 write 012
        '{1'b0,1'b1,1'b1,1'b0,4'h0,1'b0,11'h000,32'h400000A3,1'b0,32'h0,4'd4},  // R4 write 013
        '{1'b1,1'b0,1'b0,1'b0,4'h0,1'b1,11'h012,32'h0,1'b0,32'h0,4'd2},         // R2 read 012
        '{1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,11'h000,32'h0,1'b1,32'h300000A2,4'd2},  // R2 R3 -> 013
        '{1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,11'h000,32'h0,1'b1,32'h400000A3,4'd5},  // R5 -> 010
        '{1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,11'h000,32'h0,1'b1,32'h100000A0,4'd5},  // R5 -> 011
        '{1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,11'h000,32'h0,1'b1,32'h200000A1,4'd5},  // R5 wrap -> 012
        '{1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,11'h013,32'h0,1'b1,32'h300000A2,4'd6},  // R6 read 013
        '{1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,11'h000,32'h0,1'b1,32'h400000A3,4'd4},  // R4 -> 010
        '{1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,11'h000,32'h0,1'b1,32'h100000A0,4'd4},  // R4 -> 011
        '{1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,11'h000,32'h0,1'b1,32'h200000A1,4'd4},  // R4 -> 012
        '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,11'h000,32'h0,1'b1,32'h300000A2,4'd4},  // R4 idle
        '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,11'h000,32'h0,1'b0,32'h0,4'd12},        // R12 idle
        '{1'b1,1'b0,1'b0,1'b1,4'h5,1'b0,11'h010,32'h11223344,1'b0,32'h0,4'd12}, // R8 lanes 0,2
        '{1'b1,1'b0,1'b0,1'b0,4'hF,1'b0,11'h011,32'hFFFFFFFF,1'b0,32'h0,4'd8},  // R8 strobes ignored
        '{1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,11'h010,32'h0,1'b1,32'h200000A1,4'd8},  // R8 011 unchanged
        '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,11'h000,32'h0,1'b1,32'h10220044,4'd8},  // R8 merged word
        '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,11'h000,32'h0,1'b0,32'h0,4'd12},        // R12
        '{1'b1,1'b0,1'b1,1'b0,4'h0,1'b0,11'h020,32'hCAFEF00D,1'b0,32'h0,4'd7},  // R7 no strobes
        '{1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,11'h020,32'h0,1'b0,32'h0,4'd7},         // R7 read 020
        '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,11'h000,32'h0,1'b1,32'hCAFEF00D,4'd1}   // R1 R7 full word
    };

    task automatic check(input string req, input logic ev, input logic [31:0] ed);
        n_checks++;
        if (rdata_valid !== ev || rdata !== (ev ? ed : 32'h0)) begin
            n_fail++;
            $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h",
                     req, rdata_valid, rdata, ev, ev ? ed : 32'h0);
        end
    endtask

    task automatic idle();
        addr_load = 0; burst_adv = 0; wr_all = 0; wr_byte_en = 0;
        byte_sel = 0; wdata = 0; addr = 0;
    endtask

    task automatic drive(input vec_t v);
        addr_load = v.ld; burst_adv = v.adv; wr_all = v.wa; wr_byte_en = v.wbe;
        byte_sel = v.bs; burst_mode = v.md; addr = v.ad; wdata = v.wd;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1; sleep = 0; out_en = 1; burst_mode = 0;
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        check("R11 reset state", 1'b0, 32'h0);

        for (int i = 0; i < 23; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].rq, i), VECS[i].ev, VECS[i].ed);
        end

        // R9: asynchronous output enable
        idle(); addr_load = 1; addr = 11'h020;
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R2 read of 020", 1'b1, 32'hCAFEF00D);
        out_en = 0; #1;
        check("R9 out_en low", 1'b0, 32'h0);
        out_en = 1; #1;
        check("R9 out_en restored", 1'b1, 32'hCAFEF00D);

        // R10: sleep ignores cycles, holds burst state and contents
        @(negedge clk);
        burst_mode = 0; addr_load = 1; addr = 11'h010;
        @(negedge clk);
        idle(); sleep = 1; burst_adv = 1;
        @(negedge clk);
        check("R10 outputs off in sleep", 1'b0, 32'h0);
        idle(); addr_load = 1; wr_all = 1; addr = 11'h020; wdata = 32'h0;
        @(negedge clk);
        check("R10 still off in sleep", 1'b0, 32'h0);
        idle(); sleep = 0; burst_adv = 1;
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R10 counter kept across sleep", 1'b1, 32'h200000A1);
        addr_load = 1; addr = 11'h020;
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R10 write in sleep ignored", 1'b1, 32'hCAFEF00D);

        // R11: reset in mid-operation
        addr_load = 1; addr = 11'h020;
        @(negedge clk);
        idle(); rst = 1;
        @(negedge clk);
        check("R11 reset clears output", 1'b0, 32'h0);
        rst = 0;
        @(negedge clk);
        check("R11 quiet after reset", 1'b0, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule